// File: doc/BRIEF.md
# Two-Wire Command and Register Front End

This block is the serial control front end of a voice record/playback controller. It listens to a two-wire (I2C) bus, answers only to its own 7-bit device address, takes the first written byte as a command, and, when the command names a target register, assembles the following two bytes into that 16-bit register. A read that is not preceded by a command byte returns a status byte provided by the surrounding logic.

The command byte is split into fields. Bit 7 is the power request, bit 6 is the digital/analog selector, bits 5..3 are a function code and bits 2..0 select a target register. Every recognised command raises a single-cycle strobe. A separate strobe marks the cycle in which a register takes its new 16-bit value, so downstream logic can sample a complete word. The bus lines are oversampled by a fast system clock. SDA is driven open-drain through an output-enable that pulls the line low.

Top module: `i2c_cmd_regif`

## Requirements
- R1: The device answers only to address byte bits 7..1 equal to {5'b10000, strap[1:0]}. On a match it pulls SDA low in the acknowledge slot. On a mismatch it leaves SDA released and ignores every byte up to the next START or STOP.
- R2: The first byte written after a matching write address is captured on `cmd_q`.
- R3: Select codes 3'b001, 3'b010, 3'b011 and 3'b100 in command bits 2..0 load the next two bytes into `row_addr`, `cfg0`, `cfg1` and `cfg2` respectively. The first byte is bits 15..8 and the second is bits 7..0. `wr_stb` pulses for one cycle exactly when the register changes.
- R4: Select codes 3'b000, 3'b101, 3'b110 and 3'b111 are no-ops, and their data bytes leave all four registers unchanged. Bytes beyond the second payload byte are also ignored.
- R5: Command 80h pulses `pwr_up_stb` and command 00h pulses `pwr_dn_stb`.
- R6: A command with bits 7..6 = 2'b10 pulses `play_stb` for function 3'b101 (A8h), `rec_stb` for function 3'b100 (A0h) and `cue_stb` for function 3'b111 (B8h).
- R7: Command C0h pulses `dig_on_stb` and command 40h pulses `dig_off_stb`.
- R8: A matching read returns `status_i` MSB first. It keeps returning it for each byte the master acknowledges and stops after a not-acknowledge.
- R9: `row_base` equals `row_addr` with its 5 least significant bits forced to zero.
- R10: A STOP releases SDA and returns to idle. A repeated START restarts the byte count, so a payload cut short by it is dropped and the next written byte is a new command.
- R11: The command strobes are single-cycle pulses, and at most one of them is high in any cycle.
- R12: After reset SDA is released and `cmd_q` and all four registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap | input | 2 | Address low bits from strap pins |
| status_i | input | 8 | Byte returned on a status read |
| cmd_q | output | 8 | Last captured command byte |
| row_addr | output | 16 | Row address register |
| row_base | output | 16 | Row address aligned to a 32-row boundary |
| cfg0 | output | 16 | Configuration register 0 |
| cfg1 | output | 16 | Configuration register 1 |
| cfg2 | output | 16 | Configuration register 2 |
| wr_stb | output | 1 | Pulse when a register write completes |
| pwr_up_stb | output | 1 | Power-up command pulse |
| pwr_dn_stb | output | 1 | Power-down command pulse |
| play_stb | output | 1 | Play command pulse |
| rec_stb | output | 1 | Record command pulse |
| cue_stb | output | 1 | Cue command pulse |
| dig_on_stb | output | 1 | Enter digital mode pulse |
| dig_off_stb | output | 1 | Exit digital mode pulse |

## Verification
On every cycle the assertions check several properties. The command strobes never overlap and last one cycle. No register changes without `wr_stb`. SDA is released right after a STOP, and the reset state holds when reset ends. The bench scenarios are what show address filtering with the straps, the big-endian assembly into the selected register, and no-op selects and extra bytes leaving the registers untouched. They also show a repeated START dropping a half-sent payload, and the status byte repeating until the master declines.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_RX,
    BUS_RXACK,
    BUS_TX,
    BUS_TXACK,
    BUS_IGNORE
  } bus_state_t;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ROW,
    TGT_CFG0,
    TGT_CFG1,
    TGT_CFG2
  } reg_tgt_t;

  localparam logic [2:0] FN_REC  = 3'b100;
  localparam logic [2:0] FN_PLAY = 3'b101;
  localparam logic [2:0] FN_CUE  = 3'b111;

  localparam logic [7:0] CMD_PWR_UP  = 8'h80;
  localparam logic [7:0] CMD_PWR_DN  = 8'h00;
  localparam logic [7:0] CMD_DIG_ON  = 8'hC0;
  localparam logic [7:0] CMD_DIG_OFF = 8'h40;

  function automatic reg_tgt_t sel_to_tgt(input logic [2:0] sel);
    case (sel)
      3'b001:  return TGT_ROW;
      3'b010:  return TGT_CFG0;
      3'b011:  return TGT_CFG1;
      3'b100:  return TGT_CFG2;
      default: return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regif_pkg::*;
#(
  parameter int          STRAP_W = 2,
  parameter logic [4:0]  ADDR_HI = 5'b10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic               start_p,
  input  logic               stop_p,
  input  logic [STRAP_W-1:0] strap,
  input  logic [7:0]         status_i,
  output logic               sda_oe,
  output logic               rx_valid,
  output logic [7:0]         rx_byte
);
  localparam int ADDR_W = $bits(ADDR_HI) + STRAP_W;

  bus_state_t state;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic       is_addr, rw;

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    if (rst) begin
      state   <= BUS_IDLE;
      cnt     <= '0;
      sr      <= '0;
      tx      <= '0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      rx_byte <= '0;
    end else if (stop_p) begin
      state  <= BUS_IDLE;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      state   <= BUS_RX;
      is_addr <= 1'b1;
      cnt     <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        BUS_RX: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (is_addr) begin
              if (sr[7:8-ADDR_W] == {ADDR_HI, strap}) begin
                sda_oe <= 1'b1;
                rw     <= sr[0];
                state  <= BUS_RXACK;
              end else begin
                state <= BUS_IGNORE;
              end
            end else begin
              rx_valid <= 1'b1;
              rx_byte  <= sr;
              sda_oe   <= 1'b1;
              state    <= BUS_RXACK;
            end
          end
        end
        BUS_RXACK: begin
          if (scl_fall) begin
            is_addr <= 1'b0;
            if (is_addr && rw) begin
              tx     <= status_i;
              sda_oe <= ~status_i[7];
              state  <= BUS_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= BUS_RX;
            end
          end
        end
        BUS_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              state  <= BUS_TXACK;
            end else begin
              cnt    <= cnt + 4'd1;
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        BUS_TXACK: begin
          if (scl_rise && sda_s) begin
            state <= BUS_IGNORE;
          end else if (scl_fall) begin
            tx     <= status_i;
            sda_oe <= ~status_i[7];
            state  <= BUS_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import i2c_regif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        cmd_q,
  output logic [DATA_W-1:0] row_addr,
  output logic [DATA_W-1:0] cfg0,
  output logic [DATA_W-1:0] cfg1,
  output logic [DATA_W-1:0] cfg2,
  output logic              wr_stb,
  output logic              pwr_up_stb,
  output logic              pwr_dn_stb,
  output logic              play_stb,
  output logic              rec_stb,
  output logic              cue_stb,
  output logic              dig_on_stb,
  output logic              dig_off_stb
);
  localparam int NB = DATA_W / 8;
  localparam int CW = $clog2(NB + 2);

  logic [CW-1:0]     idx;
  reg_tgt_t          tgt;
  logic [DATA_W-1:0] acc, word;

  assign word = {acc[DATA_W-9:0], rx_byte};

  always_ff @(posedge clk) begin
    wr_stb      <= 1'b0;
    pwr_up_stb  <= 1'b0;
    pwr_dn_stb  <= 1'b0;
    play_stb    <= 1'b0;
    rec_stb     <= 1'b0;
    cue_stb     <= 1'b0;
    dig_on_stb  <= 1'b0;
    dig_off_stb <= 1'b0;
    if (rst) begin
      idx      <= '0;
      tgt      <= TGT_NONE;
      acc      <= '0;
      cmd_q    <= '0;
      row_addr <= '0;
      cfg0     <= '0;
      cfg1     <= '0;
      cfg2     <= '0;
    end else if (start_p) begin
      idx <= '0;
    end else if (rx_valid) begin
      if (idx == '0) begin
        cmd_q       <= rx_byte;
        tgt         <= sel_to_tgt(rx_byte[2:0]);
        idx         <= CW'(1);
        pwr_up_stb  <= (rx_byte == CMD_PWR_UP);
        pwr_dn_stb  <= (rx_byte == CMD_PWR_DN);
        dig_on_stb  <= (rx_byte == CMD_DIG_ON);
        dig_off_stb <= (rx_byte == CMD_DIG_OFF);
        play_stb    <= (rx_byte[7:6] == 2'b10) && (rx_byte[5:3] == FN_PLAY);
        rec_stb     <= (rx_byte[7:6] == 2'b10) && (rx_byte[5:3] == FN_REC);
        cue_stb     <= (rx_byte[7:6] == 2'b10) && (rx_byte[5:3] == FN_CUE);
      end else if (idx <= CW'(NB) && tgt != TGT_NONE) begin
        acc <= word;
        idx <= idx + CW'(1);
        if (idx == CW'(NB)) begin
          wr_stb <= 1'b1;
          case (tgt)
            TGT_ROW:  row_addr <= word;
            TGT_CFG0: cfg0     <= word;
            TGT_CFG1: cfg1     <= word;
            TGT_CFG2: cfg2     <= word;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif #(
  parameter int         DATA_W      = 16,
  parameter int         STRAP_W     = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10000,
  parameter int         SYNC_STAGES = 2,
  parameter int         ROW_ALIGN   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [7:0]         status_i,
  output logic [7:0]         cmd_q,
  output logic [DATA_W-1:0]  row_addr,
  output logic [DATA_W-1:0]  row_base,
  output logic [DATA_W-1:0]  cfg0,
  output logic [DATA_W-1:0]  cfg1,
  output logic [DATA_W-1:0]  cfg2,
  output logic               wr_stb,
  output logic               pwr_up_stb,
  output logic               pwr_dn_stb,
  output logic               play_stb,
  output logic               rec_stb,
  output logic               cue_stb,
  output logic               dig_on_stb,
  output logic               dig_off_stb
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic rx_valid;
  logic [7:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_byte_engine #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p), .strap(strap),
    .status_i(status_i), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_byte(rx_byte)
  );

  cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .start_p(start_p), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .cmd_q(cmd_q), .row_addr(row_addr), .cfg0(cfg0),
    .cfg1(cfg1), .cfg2(cfg2), .wr_stb(wr_stb), .pwr_up_stb(pwr_up_stb),
    .pwr_dn_stb(pwr_dn_stb), .play_stb(play_stb), .rec_stb(rec_stb),
    .cue_stb(cue_stb), .dig_on_stb(dig_on_stb), .dig_off_stb(dig_off_stb)
  );

  assign row_base = {row_addr[DATA_W-1:ROW_ALIGN], {ROW_ALIGN{1'b0}}};
endmodule

// File: rtl/i2c_cmd_regif_chk.sv
module i2c_cmd_regif_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              stop_p,
  input logic [7:0]        cmd_q,
  input logic [DATA_W-1:0] row_addr,
  input logic [DATA_W-1:0] cfg0,
  input logic [DATA_W-1:0] cfg1,
  input logic [DATA_W-1:0] cfg2,
  input logic              wr_stb,
  input logic              pwr_up_stb,
  input logic              pwr_dn_stb,
  input logic              play_stb,
  input logic              rec_stb,
  input logic              cue_stb,
  input logic              dig_on_stb,
  input logic              dig_off_stb
);
  logic [6:0] cstb;
  assign cstb = {pwr_up_stb, pwr_dn_stb, play_stb, rec_stb, cue_stb, dig_on_stb, dig_off_stb};

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cstb));

  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (cstb != '0) |=> (cstb == '0));

  p_write_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_reg_change_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable({row_addr, cfg0, cfg1, cfg2}) |-> wr_stb);

  p_pwr_up_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    pwr_up_stb |-> (cmd_q == 8'h80));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_oe);

  p_reset_state_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && cmd_q == 8'h00 && row_addr == '0 &&
                    cfg0 == '0 && cfg1 == '0 && cfg2 == '0));
endmodule

bind i2c_cmd_regif i2c_cmd_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .stop_p(stop_p), .cmd_q(cmd_q),
  .row_addr(row_addr), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
  .wr_stb(wr_stb), .pwr_up_stb(pwr_up_stb), .pwr_dn_stb(pwr_dn_stb),
  .play_stb(play_stb), .rec_stb(rec_stb), .cue_stb(cue_stb),
  .dig_on_stb(dig_on_stb), .dig_off_stb(dig_off_stb)
);

// File: tb/tb_i2c_cmd_regif.sv
module tb_i2c_cmd_regif;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [6:0] MY_ADDR = {5'b10000, STRAP};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] status_i = 8'h00;
  logic sda_oe, wr_stb, pwr_up_stb, pwr_dn_stb, play_stb, rec_stb, cue_stb;
  logic dig_on_stb, dig_off_stb;
  logic [7:0] cmd_q;
  logic [15:0] row_addr, row_base, cfg0, cfg1, cfg2;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_regif dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .status_i(status_i), .cmd_q(cmd_q), .row_addr(row_addr),
    .row_base(row_base), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
    .wr_stb(wr_stb), .pwr_up_stb(pwr_up_stb), .pwr_dn_stb(pwr_dn_stb),
    .play_stb(play_stb), .rec_stb(rec_stb), .cue_stb(cue_stb),
    .dig_on_stb(dig_on_stb), .dig_off_stb(dig_off_stb)
  );

  int n_tests = 0, n_fail = 0;
  int c_wr = 0, c_pu = 0, c_pd = 0, c_play = 0, c_rec = 0, c_cue = 0, c_don = 0, c_doff = 0;
  logic [15:0] e_row = 0, e_c0 = 0, e_c1 = 0, e_c2 = 0;
  logic [7:0] e_cmd = 0;

  always @(posedge clk) if (!rst) begin
    c_wr += int'(wr_stb);       c_pu += int'(pwr_up_stb);
    c_pd += int'(pwr_dn_stb);   c_play += int'(play_stb);
    c_rec += int'(rec_stb);     c_cue += int'(cue_stb);
    c_don += int'(dig_on_stb);  c_doff += int'(dig_off_stb);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  // write transaction: address, command, then nd payload bytes (hi, lo, lo...)
  task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input int nd,
                        input logic [15:0] d, output logic ack_a);
    logic ak;
    bus_start();
    send_byte({a, 1'b0}, ack_a);
    send_byte(cmd, ak);
    for (int i = 0; i < nd; i++) send_byte(i == 0 ? d[15:8] : d[7:0], ak);
    bus_stop();
    wq(2);
  endtask

  function automatic void model(input logic [7:0] cmd, input int nd, input logic [15:0] d);
    e_cmd = cmd;
    if (nd >= 2) case (cmd[2:0])
      3'b001: e_row = d;
      3'b010: e_c0 = d;
      3'b011: e_c1 = d;
      3'b100: e_c2 = d;
      default: ;
    endcase
  endfunction

  function automatic bit writes(input logic [7:0] cmd, input int nd);
    return nd >= 2 && cmd[2:0] inside {3'b001, 3'b010, 3'b011, 3'b100};
  endfunction

  task automatic check_regs(input string tag);
    chk(row_addr == e_row, tag, row_addr, e_row);
    chk(cfg0 == e_c0, tag, cfg0, e_c0);
    chk(cfg1 == e_c1, tag, cfg1, e_c1);
    chk(cfg2 == e_c2, tag, cfg2, e_c2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] b0, b1;
    int w0, p0;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    chk(cmd_q == 8'h00, "R12 cmd_q", cmd_q, 0);
    check_regs("R12 regs zero");

    // R3 load cfg0 big-endian, R2 command capture
    w0 = c_wr;
    wr_txn(MY_ADDR, 8'h82, 2, 16'h1234, ak);
    model(8'h82, 2, 16'h1234);
    chk(ak == 1'b1, "R1 ack on match", ak, 1);
    chk(cmd_q == 8'h82, "R2 cmd captured", cmd_q, 8'h82);
    check_regs("R3 cfg0 load");
    chk(c_wr == w0 + 1, "R3 wr_stb one pulse", c_wr - w0, 1);

    // R3/R9 row address with low bits set
    wr_txn(MY_ADDR, 8'h81, 2, 16'hABFF, ak);
    model(8'h81, 2, 16'hABFF);
    check_regs("R3 row load");
    chk(row_base == 16'hABE0, "R9 row_base aligned", row_base, 16'hABE0);

    wr_txn(MY_ADDR, 8'h83, 2, 16'h5A0F, ak); model(8'h83, 2, 16'h5A0F);
    wr_txn(MY_ADDR, 8'h84, 2, 16'hC3E1, ak); model(8'h84, 2, 16'hC3E1);
    check_regs("R3 cfg1 cfg2 load");

    // R4 no-op selects and extra bytes
    w0 = c_wr;
    wr_txn(MY_ADDR, 8'h85, 2, 16'hFFFF, ak); model(8'h85, 0, 0);
    wr_txn(MY_ADDR, 8'h87, 2, 16'h0001, ak); model(8'h87, 0, 0);
    chk(cmd_q == 8'h87, "R2 no-op cmd captured", cmd_q, 8'h87);
    check_regs("R4 no-op select");
    wr_txn(MY_ADDR, 8'h82, 4, 16'h7788, ak); model(8'h82, 2, 16'h7788);
    check_regs("R4 extra bytes ignored");
    chk(c_wr == w0 + 1, "R4 no extra write", c_wr - w0, 1);

    // R5, R6, R7 command strobes
    p0 = c_pu; wr_txn(MY_ADDR, 8'h80, 0, 0, ak);
    chk(c_pu == p0 + 1, "R5 power up strobe", c_pu - p0, 1);
    p0 = c_pd; wr_txn(MY_ADDR, 8'h00, 0, 0, ak);
    chk(c_pd == p0 + 1, "R5 power down strobe", c_pd - p0, 1);
    p0 = c_play; wr_txn(MY_ADDR, 8'hA8, 0, 0, ak);
    chk(c_play == p0 + 1, "R6 play strobe", c_play - p0, 1);
    p0 = c_rec; wr_txn(MY_ADDR, 8'hA0, 0, 0, ak);
    chk(c_rec == p0 + 1, "R6 record strobe", c_rec - p0, 1);
    p0 = c_cue; wr_txn(MY_ADDR, 8'hB8, 0, 0, ak);
    chk(c_cue == p0 + 1, "R6 cue strobe", c_cue - p0, 1);
    p0 = c_don; wr_txn(MY_ADDR, 8'hC0, 0, 0, ak);
    chk(c_don == p0 + 1, "R7 digital enter", c_don - p0, 1);
    p0 = c_doff; wr_txn(MY_ADDR, 8'h40, 0, 0, ak);
    chk(c_doff == p0 + 1, "R7 digital exit", c_doff - p0, 1);
    chk(c_play == p0 - p0 + c_play && c_pu == 1 && c_pd == 1, "R11 single pulses",
        c_pu + c_pd, 2);

    // R1 mismatched straps: nack and ignored
    b0 = cmd_q;
    wr_txn({5'b10000, ~STRAP}, 8'h83, 2, 16'hDEAD, ak);
    chk(ak == 1'b0, "R1 nack on mismatch", ak, 0);
    chk(cmd_q == b0, "R1 bytes ignored", cmd_q, b0);
    check_regs("R1 regs untouched");

    // R8 status read, repeated while acked
    status_i = 8'hA5;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ak);
    chk(ak == 1'b1, "R8 read address ack", ak, 1);
    read_byte(1'b1, b0);
    read_byte(1'b0, b1);
    bus_stop(); wq(2);
    chk(b0 == 8'hA5, "R8 status byte", b0, 8'hA5);
    chk(b1 == 8'hA5, "R8 status repeated", b1, 8'hA5);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);

    // R10 repeated start drops a half payload
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ak);
    send_byte(8'h82, ak);
    send_byte(8'h55, ak);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ak);
    send_byte(8'h83, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    bus_stop(); wq(2);
    model(8'h83, 2, 16'h1122);
    chk(cmd_q == 8'h83, "R10 new command after restart", cmd_q, 8'h83);
    check_regs("R10 restart payload");

    // random register loads
    for (int it = 0; it < 30; it++) begin
      logic [2:0] sel;
      logic [15:0] d;
      logic [7:0] cmd;
      int nd;
      logic mis;
      sel = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      nd = $urandom_range(0, 3);
      mis = ($urandom_range(0, 5) == 0);
      cmd = {5'b10000, sel};
      w0 = c_wr;
      wr_txn(mis ? {5'b10000, STRAP ^ 2'b01} : MY_ADDR, cmd, nd, d, ak);
      if (!mis) model(cmd, nd, d);
      chk(ak == !mis, "R1 random address", ak, !mis);
      chk(cmd_q == e_cmd, "R2 random cmd", cmd_q, e_cmd);
      check_regs("R3 R4 random load");
      chk(c_wr - w0 == int'(!mis && writes(cmd, nd)), "R3 random wr_stb",
          c_wr - w0, int'(!mis && writes(cmd, nd)));
      chk(row_base == (e_row & 16'hFFE0), "R9 random row_base", row_base, e_row & 16'hFFE0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule